// File: doc/BRIEF.md
# Prioritized Masked Interrupt Controller

This block watches a small set of interrupt request lines and decides whether one interrupt should be raised toward a processor. Every source owns a 3-bit priority level (0 lowest, 7 highest). A source can only compete when its request line is high and its enable bit is set. Among the competing sources the block picks the one with the highest level. It then compares that level with a 3-bit mask level that the CPU supplies. The request toward the CPU is raised only when the winning level is strictly above the mask.

Software programs the enables and priorities through a byte-wide register port. This port has an address, a write strobe, write data and combinational read data. The priority registers hold two 3-bit fields each, so one byte sets two sources. The request flag, the winning source index and the winning level are all registered outputs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, every priority register reads 0x77 (all sources at level 7), and int_req, int_src and int_level are all 0.
- R2: Address 0 selects the enable register, where bit n enables source n (1 = enabled). Address 1+k selects priority register k. In that register, bits 6:4 hold the level of source 2k and bits 2:0 hold the level of source 2k+1. Reads return the current contents in the same cycle as the address.
- R3: Reserved bits always read 0 and ignore writes. These are bits 7:6 of the enable register and bits 7 and 3 of each priority register.
- R4: A source whose enable bit is 0 never wins, even when its request line is high.
- R5: Among sources that are both pending and enabled, the one with the highest level wins.
- R6: When several pending, enabled sources share the top level, the one with the lowest index wins.
- R7: int_req is 1 only when a winner exists and its level is strictly greater than cpu_mask. With cpu_mask = 7, int_req stays 0.
- R8: int_src and int_level report the winner whether or not the mask blocks it. When no source is both pending and enabled, both read 0.
- R9: The outputs are registered. They reflect the request lines, the mask and the register contents one clock edge after those values are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 6 | Request lines, one per source |
| cpu_mask | input | 3 | Mask level supplied by the CPU |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| int_req | output | 1 | Interrupt request to the CPU |
| int_src | output | 3 | Index of the winning source |
| int_level | output | 3 | Level of the winning source |

## Verification
Three conditions are hard to reach from the ports. A tie at the top level needs several sources enabled and pending at once, all programmed to the same value. A disabled line that would otherwise win needs the highest level on a source whose enable bit is clear. A winner exactly at the mask level needs the mask to equal the winner's level. Random register writes restricted to a narrow band of levels make ties common. Directed cases cover the disabled winner, a level equal to the mask, a mask of 7 and level-0 sources.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef logic [2:0] prio_t;

  // a level passes only when strictly above the CPU mask
  function automatic logic level_passes(input prio_t lvl, input prio_t mask);
    return lvl > mask;
  endfunction

  // compose a priority byte from two fields, reserved bits forced to 0
  function automatic logic [7:0] pack_pair(input prio_t hi, input prio_t lo);
    return {1'b0, hi, 1'b0, lo};
  endfunction
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int ADDR_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  we,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output logic [NUM_SRC-1:0]    en_o,
  output logic [3*NUM_SRC-1:0]  prio_o
);
  localparam int PRIO_REGS = NUM_SRC / 2;

  logic [NUM_SRC-1:0] en_q;
  prio_t              prio_q [NUM_SRC];
  logic               unused_wbits;

  assign unused_wbits = wdata[7] ^ wdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= 3'd7;
    end else if (we) begin
      if (addr == '0) en_q <= wdata[NUM_SRC-1:0];
      for (int k = 0; k < PRIO_REGS; k++) begin
        if (addr == ADDR_W'(k + 1)) begin
          prio_q[2*k]   <= wdata[6:4];
          prio_q[2*k+1] <= wdata[2:0];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) begin
      for (int i = 0; i < NUM_SRC; i++) rdata[i] = en_q[i];
    end
    for (int k = 0; k < PRIO_REGS; k++) begin
      if (addr == ADDR_W'(k + 1)) rdata = pack_pair(prio_q[2*k], prio_q[2*k+1]);
    end
  end

  assign en_o = en_q;
  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flat
      assign prio_o[3*g +: 3] = prio_q[g];
    end
  endgenerate
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0]   cand,
  input  logic [3*NUM_SRC-1:0] prio_flat,
  output logic                 win_valid,
  output logic [IDX_W-1:0]     win_idx,
  output prio_t                win_lvl
);
  // scan from the top index down; ">=" lets a lower index take over on ties
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (!win_valid || prio_flat[3*i +: 3] >= win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = prio_flat[3*i +: 3];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 6,
  localparam int ADDR_W = $clog2(NUM_SRC / 2 + 1),
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [2:0]         cpu_mask,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               int_req,
  output logic [IDX_W-1:0]   int_src,
  output logic [2:0]         int_level
);
  logic [NUM_SRC-1:0]   en_bits;
  logic [3*NUM_SRC-1:0] prio_bits;
  logic [NUM_SRC-1:0]   cand;
  logic                 win_valid;
  logic [IDX_W-1:0]     win_idx;
  prio_t                win_lvl;
  logic                 win_passes;

  prio_irq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .rdata(reg_rdata), .en_o(en_bits), .prio_o(prio_bits)
  );

  assign cand = irq_req & en_bits;

  prio_irq_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .cand(cand), .prio_flat(prio_bits),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign win_passes = win_valid && level_passes(win_lvl, cpu_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_req   <= 1'b0;
      int_src   <= '0;
      int_level <= '0;
    end else begin
      int_req   <= win_passes;
      int_src   <= win_idx;
      int_level <= win_lvl;
    end
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NUM_SRC = 6,
  parameter int ADDR_W  = 2,
  parameter int IDX_W   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SRC-1:0]   irq_req,
  input logic [2:0]           cpu_mask,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [7:0]           reg_rdata,
  input logic [NUM_SRC-1:0]   en_bits,
  input logic [3*NUM_SRC-1:0] prio_bits,
  input logic                 int_req,
  input logic [IDX_W-1:0]     int_src,
  input logic [2:0]           int_level
);
  assert_mask_strict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> int_level > $past(cpu_mask));

  assert_mask7_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_mask) == 3'd7) |-> !int_req);

  assert_winner_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((($past(en_bits) & $past(irq_req)) >> int_src) & 1) == 1);

  assert_level_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> int_level == 3'(($past(prio_bits) >> (3 * int_src)) & 7));

  assert_enable_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == '0) |-> (reg_rdata >> NUM_SRC) == 0);

  assert_prio_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != '0) |-> (reg_rdata[7] == 1'b0 && reg_rdata[3] == 1'b0));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_bits & irq_req) == '0) |-> (int_src == '0 && int_level == '0 && !int_req));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cpu_mask(cpu_mask),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .en_bits(en_bits),
  .prio_bits(prio_bits), .int_req(int_req), .int_src(int_src), .int_level(int_level)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  localparam int N = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] irq_req = '0;
  logic [2:0] cpu_mask = '0;
  logic [1:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       int_req;
  logic [2:0] int_src;
  logic [2:0] int_level;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [5:0] sh_en = '0;
  logic [2:0] sh_lvl [N];

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cpu_mask(cpu_mask),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_req(int_req), .int_src(int_src), .int_level(int_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // bench model: ascending scan, strictly greater replaces, so ties keep lower index
  function automatic logic [6:0] model(input logic [5:0] req, input logic [2:0] mask);
    logic found = 0; logic [2:0] best = 0; logic [2:0] idx = 0;
    for (int i = 0; i < N; i++)
      if (req[i] && sh_en[i] && (!found || sh_lvl[i] > best)) begin
        found = 1; best = sh_lvl[i]; idx = 3'(i);
      end
    return {found && (best > mask), idx, best};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 0) sh_en = d[5:0];
    else begin sh_lvl[2*(a-1)] = d[6:4]; sh_lvl[2*(a-1)+1] = d[2:0]; end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    if (a == 0) return {2'b00, sh_en};
    return {1'b0, sh_lvl[2*(a-1)], 1'b0, sh_lvl[2*(a-1)+1]};
  endfunction

  task automatic rd_chk(input logic [1:0] a, input string tag);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp_read(a));
  endtask

  // apply inputs at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic apply_chk(input logic [5:0] req, input logic [2:0] mask, input string tag);
    logic [6:0] e;
    @(negedge clk);
    irq_req = req; cpu_mask = mask;
    @(negedge clk);
    e = model(req, mask);
    chk({tag, " req"}, int_req, e[6]);
    chk({tag, " src"}, int_src, e[5:3]);
    chk({tag, " lvl"}, int_level, e[2:0]);
  endtask

  initial begin
    for (int i = 0; i < N; i++) sh_lvl[i] = 3'd7;
    void'($urandom(32'h51ce));
    #20; @(negedge clk); rst_n = 1'b1;

    // R1 reset values
    for (int a = 0; a < 4; a++) rd_chk(2'(a), "R1 reset register");
    chk("R1 reset int_req", int_req, 0);
    chk("R1 reset int_src", int_src, 0);
    chk("R1 reset int_level", int_level, 0);

    // R2 R3 register map and reserved bits
    wr(0, 8'hFF); rd_chk(0, "R3 enable reserved");
    wr(1, 8'hFF); rd_chk(1, "R3 prio reserved");
    wr(2, 8'h35); rd_chk(2, "R2 prio fields");
    wr(3, 8'h12); rd_chk(3, "R2 prio fields");

    // levels: s0=7 s1=7 s2=3 s3=5 s4=1 s5=2
    apply_chk(6'b111100, 3'd0, "R5 highest wins");     // s3 level 5
    apply_chk(6'b000011, 3'd0, "R6 tie lower index");  // s0
    apply_chk(6'b111111, 3'd7, "R7 mask 7 blocks");
    apply_chk(6'b001000, 3'd5, "R7 equal to mask");
    apply_chk(6'b001000, 3'd4, "R7 just above mask");
    apply_chk(6'b000000, 3'd0, "R8 none pending");

    // R4 disabled top-level source
    wr(0, 8'b0011_1110);
    apply_chk(6'b000011, 3'd0, "R4 disabled s0");       // s1 wins
    wr(0, 8'b0011_1100);
    apply_chk(6'b000011, 3'd0, "R4 all disabled");

    // R9 one-edge latency
    wr(0, 8'h3F);
    wr(3, 8'h00);
    apply_chk(6'b000000, 3'd0, "R9 setup");
    @(negedge clk); irq_req = 6'b010000; cpu_mask = 3'd0;
    #1 chk("R9 before edge", int_req, 0);
    chk("R8 level0 winner src before", int_src, 0);
    @(negedge clk);
    chk("R8 level0 winner src", int_src, 4);
    chk("R7 level0 never passes", int_req, 0);
    wr(2, 8'h66);
    @(negedge clk); irq_req = 6'b001100;
    @(negedge clk);
    chk("R9 after edge req", int_req, 1);
    chk("R6 tie src", int_src, 2);

    // random mix, narrow levels to provoke ties
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 3);
      if (op == 0) wr(2'($urandom_range(0, 3)), 8'($urandom));
      else if (op == 1) wr(2'($urandom_range(1, 3)),
                           {1'b0, 3'($urandom_range(4, 5)), 1'b0, 3'($urandom_range(4, 5))});
      rd_chk(2'($urandom_range(0, 3)), "R2 random read");
      apply_chk(6'($urandom), 3'($urandom_range(0, 7)), "R5 random");
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin repeat (20000) @(posedge clk);
            errors++; checks++; $display("FAIL watchdog: actual hang expected finish"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule